// File: doc/BRIEF.md
# UART Transmitter with Holding Register

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding register. A separate shift register turns that byte into a serial frame on the line output. A one-cycle bit tick from an external baud generator sets the pace. Each frame has one start bit (low), then eight data bits with the least significant bit first, then one stop bit (high). Every bit lasts from one tick to the next.

A single empty flag tells software when it may write the next byte, and the interrupt output mirrors this flag. The flag is not set when the holding register is copied into the shift register. It is set only after the start bit and the first data bit of the new character have left the line. From that point, seven data bits and the stop bit remain to be sent, which gives software a known window to reload the holding register.

If a byte is waiting when a stop bit ends, its start bit follows at once, with no idle bit in between. Otherwise the line rests high.

Top module: `uart_txh`

## Requirements
- R1: After reset, `txd_o` is 1, `empty_o` is 1 and `irq_o` is 1.
- R2: `irq_o` always equals `empty_o`.
- R3: A write (`wr_en_i` high for one cycle) clears `empty_o` to 0 from the next cycle on.
- R4: `txd_o` changes only in the cycle that follows a cycle with `bit_tick_i` high. The frame is sent in this order: a start bit of 0, then data bits 0 through 7, then a stop bit of 1.
- R5: When the line is idle and a byte is pending, the start bit appears on the first bit tick after the write, not before.
- R6: `empty_o` rises at the tick that ends data bit 0 of the character being sent. That is the same tick that puts data bit 1 on the line.
- R7: While a written byte has not yet been moved into the shift register, `empty_o` stays 0.
- R8: If a byte is pending when a stop bit ends, the tick that ends the stop bit starts the pending byte's start bit.
- R9: With no pending byte, the tick that ends a stop bit returns the line to idle high. Further ticks keep it high and leave `empty_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| bit_tick_i | input | 1 | One-cycle bit-rate enable |
| txd_o | output | 1 | Serial line output, idle high |
| empty_o | output | 1 | Holding register may be written |
| irq_o | output | 1 | Transmit interrupt, equal to the empty flag |

## Verification
The assertions assume that `bit_tick_i` is a single-cycle pulse with at least one cycle between pulses. They also assume that a write is issued only while `empty_o` is 1, or while the line is idle. The bench keeps to these rules: it raises the tick for one cycle and then waits idle cycles, and its write task checks the empty flag before every write. Any write made while the flag is low is counted as a protocol violation. The bench never depends on the overwrite behaviour.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
  localparam int unsigned TXH_DATA_W = 8;
endpackage

// File: rtl/txh_hold.sv
module txh_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              first_done_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      full_o  <= 1'b0;
      empty_o <= 1'b1;
    end else begin
      if (wr_en_i) data_o <= wr_data_i;
      if (wr_en_i)     full_o <= 1'b1;
      else if (load_i) full_o <= 1'b0;
      // flag waits for the first data bit to leave, and only if nothing is queued
      if (wr_en_i)                         empty_o <= 1'b0;
      else if (first_done_i && !full_o)    empty_o <= 1'b1;
    end
  end

  assert_write_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !empty_o);
  assert_full_not_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);
endmodule

// File: rtl/txh_shift.sv
module txh_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned STOP_POS = DATA_W + 1,
  localparam int unsigned POS_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              load_o,
  output logic              first_done_o,
  output logic              busy_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              txd_o
);
  logic [DATA_W-1:0] sh_q;
  logic              at_stop;

  always_comb begin
    at_stop      = busy_o && (pos_o == POS_W'(STOP_POS));
    load_o       = tick_i && hold_full_i && (!busy_o || at_stop);
    first_done_o = tick_i && busy_o && (pos_o == POS_W'(1));
    if (!busy_o)                txd_o = 1'b1;
    else if (pos_o == '0)       txd_o = 1'b0;
    else if (at_stop)           txd_o = 1'b1;
    else                        txd_o = sh_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
      sh_q   <= '0;
    end else if (load_o) begin
      busy_o <= 1'b1;
      pos_o  <= '0;
      sh_q   <= load_data_i;
    end else if (tick_i && busy_o) begin
      if (at_stop) begin
        busy_o <= 1'b0;
        pos_o  <= '0;
      end else begin
        pos_o <= pos_o + POS_W'(1);
        if (pos_o != '0) sh_q <= sh_q >> 1;
      end
    end
  end

  assert_line_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(txd_o));
endmodule

// File: rtl/uart_txh.sv
module uart_txh
  import uart_txh_pkg::*;
#(
  parameter int unsigned DATA_W = TXH_DATA_W,
  localparam int unsigned POS_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_tick_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              irq_o
);
  logic              load, first_done, hold_full, busy;
  logic [DATA_W-1:0] hold_data;
  logic [POS_W-1:0]  pos;

  txh_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .load_i(load), .first_done_i(first_done),
    .data_o(hold_data), .full_o(hold_full), .empty_o(empty_o)
  );

  txh_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(bit_tick_i), .hold_full_i(hold_full), .load_data_i(hold_data),
    .load_o(load), .first_done_o(first_done),
    .busy_o(busy), .pos_o(pos), .txd_o(txd_o)
  );

  assign irq_o = empty_o;

  assert_empty_after_bit0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> busy && (pos == POS_W'(2)));
  assert_no_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && busy && pos == POS_W'(DATA_W + 1) && hold_full) |=> (busy && pos == '0 && !txd_o));
  assert_idle_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !bit_tick_i) |=> !busy);
endmodule

// File: tb/tb_uart_txh.sv
module tb_uart_txh;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       txd, empty, irq;
  int checks = 0, failures = 0, violations = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_txh dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .bit_tick_i(tick), .txd_o(txd), .empty_o(empty), .irq_o(irq)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    if (!empty) begin
      violations++;
      $display("protocol violation: write while flag low");
    end
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    chk(empty, 1'b0, "R3 empty after write");
    chk(irq, empty, "R2 irq mirrors empty");
  endtask

  task automatic do_tick();
    logic held;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    held = txd;
    repeat (2) @(negedge clk);
    chk(txd, held, "R4 line stable between ticks");
  endtask

  // send one frame; optionally write next byte after bit index wr_at
  task automatic frame(input logic [7:0] d, input int wr_at, input logic [7:0] nd);
    logic exp_bit;
    for (int i = 0; i < 10; i++) begin
      do_tick();
      exp_bit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
      chk(txd, exp_bit, (i == 0) ? "R5 start bit" : (i == 9) ? "R4 stop bit" : "R4 data bit");
      chk(empty, (i >= 2) && !(wr_at >= 0 && i > wr_at), "R6 empty timing");
      chk(irq, empty, "R2 irq mirrors empty");
      if (i == wr_at) begin
        do_write(nd);
        chk(empty, 1'b0, "R7 pending keeps empty low");
      end
    end
  endtask

  task automatic t_reset();
    chk(txd, 1'b1, "R1 txd reset");
    chk(empty, 1'b1, "R1 empty reset");
    chk(irq, 1'b1, "R1 irq reset");
  endtask

  task automatic t_idle_ticks();
    for (int k = 0; k < 3; k++) begin
      do_tick();
      chk(txd, 1'b1, "R9 idle high");
      chk(empty, 1'b1, "R9 empty stays set");
    end
  endtask

  task automatic t_single(input logic [7:0] d);
    do_write(d);
    repeat (3) @(negedge clk);
    chk(txd, 1'b1, "R5 no start before tick");
    frame(d, -1, 8'h00);
    do_tick();
    chk(txd, 1'b1, "R9 idle after stop");
    chk(empty, 1'b1, "R9 empty after frame");
  endtask

  task automatic t_back_to_back(input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] c, input int wa, input int wb);
    do_write(a);
    frame(a, wa, b);
    frame(b, wb, c);   // R8 start bit follows stop with no gap
    frame(c, -1, 8'h00);
    do_tick();
    chk(txd, 1'b1, "R9 idle after chain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ticks();
    t_single(8'hA5);
    t_single(8'h01);
    t_single(8'h80);
    t_back_to_back(8'hFF, 8'h00, 8'h3C, 2, 8);
    t_back_to_back(8'h5A, 8'hC3, 8'h7E, 5, 3);
    t_idle_ticks();
    chk(violations == 0, 1'b1, "R3 bench obeyed write protocol");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule